// File: doc/BRIEF.md
# Double-Buffered Bulk Endpoint Byte Buffer

This block is a two-bank ping-pong byte buffer for one bulk endpoint of a USB device. Each bank holds a single packet of up to 64 bytes, so 128 bytes are stored in all. The writing side fills one bank. The reading side drains the other. When a packet is finished, the banks trade places, so the bus engine and the local microcontroller can work at the same time without waiting on each other.

The block works in either direction. In receive mode the USB engine writes and the microcontroller reads. In transmit mode the microcontroller writes and the USB engine reads. A single direction input picks which side's write and read ports are live. A packet is closed in one of two ways: the 64th byte arrives, or the writer raises an end strobe. A closed packet is offered to the reader together with its byte count.

Three flags report status. The full flag describes the bank that is under the write pointer. The empty flag describes the bank that is under the read pointer. A busy flag tells the writer that both banks hold unread packets.

Top module: `usb_pingpong_fifo`

## Requirements
- R1: After a hardware reset (rst_n low), full, busy and pkt_ready read 0, empty reads 1 and rd_len reads 0.
- R2: Bytes accepted on the write side come out on the read side in the same order. While empty is 0, the read data port already shows the next unread byte, and a read strobe moves to the following byte.
- R3: A bank is closed in the cycle its 64th byte is written, with no end strobe needed, and its rd_len then reads 64.
- R4: The end strobe closes a short packet. It may come together with the packet's last byte (count includes that byte) or alone (count is the bytes pending). An end strobe alone when no bytes are pending is ignored.
- R5: full is 1 only while the bank under the write pointer holds a closed 64-byte packet that is waiting for the other bank to be freed. A short packet never raises full.
- R6: empty is 1 exactly when the bank under the read pointer holds no closed packet.
- R7: pkt_ready is 1 while at least one closed bank is waiting to be read.
- R8: busy is 1 when both banks hold closed, unread packets. While busy is 1, written bytes and end strobes are ignored and leave stored data unchanged.
- R9: A bank is released to the writer in the cycle its last counted byte is read. Read strobes while empty is 1 are ignored.
- R10: When dir_tx is 0, the usb_wr_* ports write and mcu_rd_* reads. When dir_tx is 1, the mcu_wr_* ports write and usb_rd_* reads. The inactive side's write inputs are ignored, and the inactive read data port is 0.
- R11: A change of dir_tx or a high bus_rst flushes both banks in that cycle, and any write or read in that cycle is ignored. On the next cycle the outputs are as in R1.
- R12: If a write-side close and a read-side release fall in the same cycle, the writer moves straight to the freed bank, busy stays 0, and the new packet becomes readable at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_rst | input | 1 | Synchronous flush of both banks |
| dir_tx | input | 1 | 0: USB engine writes; 1: microcontroller writes |
| usb_wr_en | input | 1 | USB side byte write strobe |
| usb_wr_data | input | 8 | USB side write byte |
| usb_eop | input | 1 | USB side end-of-packet strobe |
| usb_rd_en | input | 1 | USB side byte read strobe |
| usb_rd_data | output | 8 | USB side read byte (0 when not reading side) |
| mcu_wr_en | input | 1 | Controller side byte write strobe |
| mcu_wr_data | input | 8 | Controller side write byte |
| mcu_eop | input | 1 | Controller side end-of-packet strobe |
| mcu_rd_en | input | 1 | Controller side byte read strobe |
| mcu_rd_data | output | 8 | Controller side read byte (0 when not reading side) |
| full | output | 1 | Write-side bank holds a waiting 64-byte packet |
| empty | output | 1 | Read-side bank holds no closed packet |
| busy | output | 1 | Both banks occupied; writes blocked |
| pkt_ready | output | 1 | At least one closed packet waits |
| rd_len | output | 7 | Byte count of the packet under the read pointer |

## Verification
Two things can happen in the same cycle: the writer closing its bank and the reader pulling the last byte out of the other bank. Either event moves the bank pointers. The bench sets this up by writing the last byte of a second packet, together with its end strobe, in the very cycle the final byte of the first packet is read. It then checks three things: busy stays 0, the new packet is offered with the right count, and a third packet goes into the freed bank. The checker also watches each such coincidence, and it requires that busy stays low on the following cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } pp_dir_e;

  // Linear storage index of byte idx inside a bank.
  function automatic int unsigned pp_flat_index(input logic bank,
                                                input int unsigned idx,
                                                input int unsigned depth);
    return (bank ? depth : 0) + idx;
  endfunction

  // A bank closes once it holds depth bytes, or on an end strobe with data pending.
  function automatic logic pp_closes(input int unsigned filled,
                                     input logic eop,
                                     input int unsigned depth);
    return (filled == depth) || (eop && (filled != 0));
  endfunction

endpackage

// File: rtl/pp_port_mux.sv
module pp_port_mux #(
  parameter int DATA_W = 8
) (
  input  logic              dir_tx,
  input  logic              usb_wr_en,
  input  logic [DATA_W-1:0] usb_wr_data,
  input  logic              usb_eop,
  input  logic              usb_rd_en,
  output logic [DATA_W-1:0] usb_rd_data,
  input  logic              mcu_wr_en,
  input  logic [DATA_W-1:0] mcu_wr_data,
  input  logic              mcu_eop,
  input  logic              mcu_rd_en,
  output logic [DATA_W-1:0] mcu_rd_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              eop,
  output logic              rd_en,
  input  logic [DATA_W-1:0] rd_data
);
  import pp_pkg::*;

  logic tx_sel;
  assign tx_sel = (dir_tx == DIR_TX);

  always_comb begin
    if (tx_sel) begin
      wr_en       = mcu_wr_en;
      wr_data     = mcu_wr_data;
      eop         = mcu_eop;
      rd_en       = usb_rd_en;
      usb_rd_data = rd_data;
      mcu_rd_data = '0;
    end else begin
      wr_en       = usb_wr_en;
      wr_data     = usb_wr_data;
      eop         = usb_eop;
      rd_en       = mcu_rd_en;
      usb_rd_data = '0;
      mcu_rd_data = rd_data;
    end
  end

endmodule

// File: rtl/pp_storage.sv
module pp_storage #(
  parameter int DATA_W = 8,
  parameter int WORDS  = 128,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl #(
  parameter int DEPTH   = 64,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic              eop,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic              wr_accept,
  output logic              close_ev,
  output logic              rel_ev,
  output logic              full,
  output logic              empty,
  output logic              busy,
  output logic              pkt_ready,
  output logic [CNT_W-1:0]  rd_len
);
  import pp_pkg::*;

  logic [1:0]       ready_q;
  logic [CNT_W-1:0] len_q [2];
  logic             wb_q, rb_q;
  logic [CNT_W-1:0] wcnt_q, rcnt_q;

  logic [CNT_W-1:0] wfill;
  logic             rd_accept;
  logic             other_free;
  logic             wb_move;

  assign busy      = ready_q[wb_q];
  assign wr_accept = wr_en && !busy && !flush;
  assign wfill     = wcnt_q + CNT_W'(wr_accept);
  assign close_ev  = !flush && !busy && pp_closes(32'(wfill), eop, DEPTH);

  assign rd_accept = rd_en && ready_q[rb_q] && !flush;
  assign rel_ev    = rd_accept && ((rcnt_q + CNT_W'(1)) == len_q[rb_q]);

  // The other bank counts as free if it is released in this very cycle.
  assign other_free = !ready_q[~wb_q] || (rel_ev && (rb_q != wb_q));
  assign wb_move    = close_ev ? other_free : (busy && rel_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
      wb_q     <= 1'b0;
      rb_q     <= 1'b0;
      wcnt_q   <= '0;
      rcnt_q   <= '0;
    end else if (flush) begin
      ready_q  <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
      wb_q     <= 1'b0;
      rb_q     <= 1'b0;
      wcnt_q   <= '0;
      rcnt_q   <= '0;
    end else begin
      if (rel_ev) begin
        ready_q[rb_q] <= 1'b0;
        rb_q          <= ~rb_q;
        rcnt_q        <= '0;
      end else if (rd_accept) begin
        rcnt_q <= rcnt_q + CNT_W'(1);
      end
      if (close_ev) begin
        ready_q[wb_q] <= 1'b1;
        len_q[wb_q]   <= wfill;
      end
      if (wb_move) begin
        wb_q   <= ~wb_q;
        wcnt_q <= '0;
      end else begin
        wcnt_q <= wfill;
      end
    end
  end

  assign waddr     = ADDR_W'(pp_flat_index(wb_q, 32'(wcnt_q), DEPTH));
  assign raddr     = ADDR_W'(pp_flat_index(rb_q, 32'(rcnt_q), DEPTH));
  assign full      = busy && (wcnt_q == CNT_W'(DEPTH));
  assign empty     = !ready_q[rb_q];
  assign pkt_ready = |ready_q;
  assign rd_len    = ready_q[rb_q] ? len_q[rb_q] : '0;

endmodule

// File: rtl/usb_pingpong_fifo.sv
module usb_pingpong_fifo #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              dir_tx,
  input  logic              usb_wr_en,
  input  logic [DATA_W-1:0] usb_wr_data,
  input  logic              usb_eop,
  input  logic              usb_rd_en,
  output logic [DATA_W-1:0] usb_rd_data,
  input  logic              mcu_wr_en,
  input  logic [DATA_W-1:0] mcu_wr_data,
  input  logic              mcu_eop,
  input  logic              mcu_rd_en,
  output logic [DATA_W-1:0] mcu_rd_data,
  output logic              full,
  output logic              empty,
  output logic              busy,
  output logic              pkt_ready,
  output logic [CNT_W-1:0]  rd_len
);

  logic              dir_q;
  logic              flush;
  logic              wr_en, eop, rd_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_accept, close_ev, rel_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_tx;
  end

  assign flush = bus_rst || (dir_tx != dir_q);

  pp_port_mux #(.DATA_W(DATA_W)) u_mux (
    .dir_tx      (dir_tx),
    .usb_wr_en   (usb_wr_en),
    .usb_wr_data (usb_wr_data),
    .usb_eop     (usb_eop),
    .usb_rd_en   (usb_rd_en),
    .usb_rd_data (usb_rd_data),
    .mcu_wr_en   (mcu_wr_en),
    .mcu_wr_data (mcu_wr_data),
    .mcu_eop     (mcu_eop),
    .mcu_rd_en   (mcu_rd_en),
    .mcu_rd_data (mcu_rd_data),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .eop         (eop),
    .rd_en       (rd_en),
    .rd_data     (rd_data)
  );

  pp_bank_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (wr_en),
    .eop       (eop),
    .rd_en     (rd_en),
    .waddr     (waddr),
    .raddr     (raddr),
    .wr_accept (wr_accept),
    .close_ev  (close_ev),
    .rel_ev    (rel_ev),
    .full      (full),
    .empty     (empty),
    .busy      (busy),
    .pkt_ready (pkt_ready),
    .rd_len    (rd_len)
  );

  pp_storage #(.DATA_W(DATA_W), .WORDS(2 * DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_accept),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/pp_fifo_chk.sv
module pp_fifo_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             close_ev,
  input logic             rel_ev,
  input logic             full,
  input logic             empty,
  input logic             busy,
  input logic             pkt_ready,
  input logic [CNT_W-1:0] rd_len
);

  // R11
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !full && !busy && !pkt_ready));

  // R5
  full_needs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> busy);

  // R7
  ready_matches_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready != empty);

  // R9
  len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !rel_ev && !flush) |=> $stable(rd_len));

  // R6
  empty_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> ($past(rel_ev) || $past(flush)));

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rel_ev && !flush) |=> busy);

  // R12
  swap_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_ev && rel_ev) |=> !busy);

endmodule

bind usb_pingpong_fifo pp_fifo_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .close_ev  (close_ev),
  .rel_ev    (rel_ev),
  .full      (full),
  .empty     (empty),
  .busy      (busy),
  .pkt_ready (pkt_ready),
  .rd_len    (rd_len)
);

// File: tb/usb_pingpong_fifo_bench.sv
module usb_pingpong_fifo_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       dir_tx = 1'b0;
  logic       usb_wr_en = 1'b0, usb_eop = 1'b0, usb_rd_en = 1'b0;
  logic [7:0] usb_wr_data = '0;
  logic [7:0] usb_rd_data;
  logic       mcu_wr_en = 1'b0, mcu_eop = 1'b0, mcu_rd_en = 1'b0;
  logic [7:0] mcu_wr_data = '0;
  logic [7:0] mcu_rd_data;
  logic       full, empty, busy, pkt_ready;
  logic [6:0] rd_len;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_pingpong_fifo u_usb_pingpong_fifo (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .dir_tx(dir_tx),
    .usb_wr_en(usb_wr_en), .usb_wr_data(usb_wr_data), .usb_eop(usb_eop),
    .usb_rd_en(usb_rd_en), .usb_rd_data(usb_rd_data),
    .mcu_wr_en(mcu_wr_en), .mcu_wr_data(mcu_wr_data), .mcu_eop(mcu_eop),
    .mcu_rd_en(mcu_rd_en), .mcu_rd_data(mcu_rd_data),
    .full(full), .empty(empty), .busy(busy), .pkt_ready(pkt_ready), .rd_len(rd_len)
  );

  function automatic logic [7:0] pat(input int pkt, input int i);
    return 8'((pkt * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    usb_wr_en = 0; usb_eop = 0; usb_rd_en = 0;
    mcu_wr_en = 0; mcu_eop = 0; mcu_rd_en = 0;
  endtask

  // Drive the live write side (per dir_tx) without advancing time.
  task automatic set_wr(input logic [7:0] d, input bit we, input bit last);
    if (!dir_tx) begin usb_wr_en = we; usb_wr_data = d; usb_eop = last; end
    else         begin mcu_wr_en = we; mcu_wr_data = d; mcu_eop = last; end
  endtask

  task automatic set_rd();
    if (!dir_tx) mcu_rd_en = 1'b1;
    else         usb_rd_en = 1'b1;
  endtask

  function automatic int live_rd();
    return dir_tx ? int'(usb_rd_data) : int'(mcu_rd_data);
  endfunction

  function automatic int idle_rd();
    return dir_tx ? int'(mcu_rd_data) : int'(usb_rd_data);
  endfunction

  task automatic put(input logic [7:0] d, input bit last);
    set_wr(d, 1'b1, last);
    tick();
    clear_in();
  endtask

  task automatic eop_only();
    set_wr(8'h00, 1'b0, 1'b1);
    tick();
    clear_in();
  endtask

  task automatic get(input logic [7:0] exp, input string tag);
    chk(int'(empty), 0, {tag, " R6 not empty"});
    chk(live_rd(), int'(exp), {tag, " R2 data"});
    set_rd();
    tick();
    clear_in();
  endtask

  task automatic send_pkt(input int pkt, input int len, input bit use_eop);
    for (int i = 0; i < len; i++) put(pat(pkt, i), use_eop && (i == len - 1));
  endtask

  task automatic recv_pkt(input int pkt, input int len, input string tag);
    chk(int'(rd_len), len, {tag, " R3/R4 rd_len"});
    for (int i = 0; i < len; i++) get(pat(pkt, i), tag);
  endtask

  task automatic check_idle(input string tag);
    chk(int'(full), 0, {tag, " R1 full"});
    chk(int'(empty), 1, {tag, " R1 empty"});
    chk(int'(busy), 0, {tag, " R1 busy"});
    chk(int'(pkt_ready), 0, {tag, " R1 pkt_ready"});
    chk(int'(rd_len), 0, {tag, " R1 rd_len"});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check_idle("R1 reset");
    rst_n = 1'b1;
    tick();
    check_idle("R1 after release");

    // Length sweep in both directions; R3 at 64 with no strobe, R4 otherwise.
    for (int d = 0; d < 2; d++) begin
      dir_tx = d[0];
      tick();
      for (int len = 1; len <= 64; len++) begin
        send_pkt(len + 100 * d, len, len < 64);
        chk(int'(pkt_ready), 1, "R7 ready after close");
        chk(int'(full), 0, "R5 full with one bank closed");
        chk(int'(busy), 0, "R8 busy with one bank closed");
        chk(idle_rd(), 0, "R10 idle read port zero");
        recv_pkt(len + 100 * d, len, "sweep");
        chk(int'(empty), 1, "R9 released after last byte");
        chk(int'(pkt_ready), 0, "R7 none waiting");
      end
    end

    // Back to receive; R11 flush on the change.
    dir_tx = 1'b0;
    tick();
    check_idle("R11 dir change");

    // R5/R8: two max packets fill both banks.
    send_pkt(200, 64, 0);
    chk(int'(full), 0, "R5 first max packet, writer moved on");
    send_pkt(201, 64, 0);
    chk(int'(busy), 1, "R8 both banks closed");
    chk(int'(full), 1, "R5 blocked max packet");
    put(8'hEE, 1'b0);
    put(8'hDD, 1'b1);
    eop_only();
    chk(int'(full), 1, "R8 still full after ignored writes");
    recv_pkt(200, 64, "R8 first");
    chk(int'(busy), 0, "R9 release unblocks");
    chk(int'(full), 0, "R5 writer on fresh bank");
    chk(int'(pkt_ready), 1, "R7 second waiting");
    recv_pkt(201, 64, "R8 second unchanged");
    chk(int'(empty), 1, "R6 both drained");

    // R5: short packets in both banks never raise full.
    send_pkt(210, 10, 1);
    send_pkt(211, 5, 1);
    chk(int'(busy), 1, "R8 short packets block");
    chk(int'(full), 0, "R5 short never full");
    recv_pkt(210, 10, "R5 short a");
    recv_pkt(211, 5, "R5 short b");

    // R4: end strobe alone.
    send_pkt(220, 5, 0);
    chk(int'(pkt_ready), 0, "R4 open bank not offered");
    eop_only();
    chk(int'(rd_len), 5, "R4 strobe alone count");
    recv_pkt(220, 5, "R4 strobe alone");
    eop_only();
    chk(int'(pkt_ready), 0, "R4 strobe with nothing pending ignored");

    // R9: reads while empty ignored.
    for (int i = 0; i < 3; i++) begin set_rd(); tick(); clear_in(); end
    send_pkt(230, 3, 1);
    recv_pkt(230, 3, "R9 after empty reads");

    // R10: inactive side writes ignored.
    mcu_wr_en = 1'b1; mcu_wr_data = 8'h55; mcu_eop = 1'b1;
    tick();
    clear_in();
    chk(int'(pkt_ready), 0, "R10 inactive write ignored");
    send_pkt(240, 4, 1);
    recv_pkt(240, 4, "R10 live side after ignore");

    // R12: close and release in the same cycle.
    send_pkt(250, 4, 1);
    for (int i = 0; i < 3; i++) get(pat(250, i), "R12 pre");
    for (int i = 0; i < 3; i++) put(pat(251, i), 1'b0);
    chk(live_rd(), int'(pat(250, 3)), "R12 last byte shown");
    set_wr(pat(251, 3), 1'b1, 1'b1);
    set_rd();
    tick();
    clear_in();
    chk(int'(busy), 0, "R12 no stall");
    chk(int'(pkt_ready), 1, "R12 new packet offered");
    chk(int'(rd_len), 4, "R12 new count");
    send_pkt(252, 2, 1);
    chk(int'(busy), 1, "R12 third packet in freed bank");
    chk(int'(full), 0, "R12 short third not full");
    recv_pkt(251, 4, "R12 second");
    recv_pkt(252, 2, "R12 third");

    // R11: bus reset and direction change flush, with same-cycle write ignored.
    send_pkt(260, 6, 1);
    bus_rst = 1'b1;
    set_wr(8'h77, 1'b1, 1'b1);
    tick();
    bus_rst = 1'b0;
    clear_in();
    check_idle("R11 bus reset");
    send_pkt(261, 6, 1);
    dir_tx = 1'b1;
    tick();
    check_idle("R11 direction flush");
    send_pkt(262, 7, 1);
    recv_pkt(262, 7, "R11 fresh after flush");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule